// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that completes one instruction per clock. It runs a small subset of a classic load/store instruction set: register-to-register add, subtract, and, or and signed set-less-than; word load; word store; and branch-if-equal. The program lives in a read-only instruction store. Its contents come from a parameter, so the program is fixed when the core is elaborated. The data store holds 32-bit words. On reset it takes its contents from a second parameter.

A decoder looks at the opcode of each instruction. It sets the write-back target select, the second ALU operand select, the write-back source select, the register write strobe, the memory write strobe, the branch qualifier and a two-bit ALU mode. A second, smaller decoder turns the ALU mode and the function field into one ALU operation. The program counter advances by four on every clock. It takes the branch target instead only when the branch qualifier is set and the ALU reports a zero result.

The fetch address, the fetched word and both write-back paths are brought out as outputs. A test environment can follow every architectural change through them.

Top module: `sc_core`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, that edge sets the program counter to 0. It clears registers 1 to 31. It loads data word i with word i of `DMEM_INIT`.
- R2: Outside reset, an instruction that is not a taken branch moves the program counter to PC+4 at the next edge. `instr_o` is always the program word at index PC[9:2].
- R3: Opcode 0x04 (branch-if-equal) compares the registers named in bits 25-21 and 20-16. If they are equal, the next PC is PC+4 plus the sign-extended 16-bit offset shifted left by 2; otherwise it is PC+4. A negative offset branches backwards. The instruction writes neither the registers nor memory.
- R4: Opcode 0x00 writes the register named in bits 15-11. The value written depends on the function field in bits 5-0: 0x20 gives rs+rt, 0x22 gives rs-rt, 0x24 gives rs AND rt, and 0x25 gives rs OR rt. 0x2A gives 1 if rs is less than rt as signed numbers and 0 otherwise. The instruction does not write memory.
- R5: Opcode 0x23 (load word) forms the address as rs plus the sign-extended bits 15-0. It writes data word address[9:2] into the register named in bits 20-16. It does not write memory, even though the old rt value is present on the store-data path.
- R6: Opcode 0x2B (store word) writes the value of the register named in bits 20-16 into data word address[9:2]. The address is formed as in R5. The instruction writes no register.
- R7: Register 0 always reads as zero. A write aimed at it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction word fetched at `pc_o` |
| rf_we_o | output | 1 | Register write strobe from the decoder (the register file drops writes aimed at register 0) |
| rf_waddr_o | output | 5 | Register index being written |
| rf_wdata_o | output | 32 | Value being written to the register file |
| dm_we_o | output | 1 | Data store write strobe |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (second register read value) |

## Verification
The test program takes one forward branch and skips one, and it runs a counting loop that closes with a backward branch. A core that extended the branch offset incorrectly would leave the loop in the wrong place or never return to its head. Inside a negative offset, a load follows a store to the same word. The program also writes register 0 and reads it back through a later add, so a write to register 0 that is not dropped shows up as a nonzero sum. A signed set-less-than with a negative operand would give the opposite result if the comparison were unsigned. Halfway through the loop a second reset is applied; a register file that does not clear would change the number of loop passes. Every load is checked for a stray memory write, since the old value of its destination register is present on the store-data path.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

   localparam int unsigned XLEN   = 32;
   localparam int unsigned REG_AW = 5;

   typedef enum logic [5:0] {
      OPC_RTYPE = 6'h00,
      OPC_BEQ   = 6'h04,
      OPC_LW    = 6'h23,
      OPC_SW    = 6'h2B
   } opcode_e;

   typedef enum logic [5:0] {
      FN_ADD = 6'h20,
      FN_SUB = 6'h22,
      FN_AND = 6'h24,
      FN_OR  = 6'h25,
      FN_SLT = 6'h2A
   } funct_e;

   typedef enum logic [1:0] {
      AOP_ADD   = 2'b00,
      AOP_SUB   = 2'b01,
      AOP_FUNCT = 2'b10
   } aluop_e;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_fn_e;

   typedef struct packed {
      logic   dst_is_rd;
      logic   b_is_imm;
      logic   wb_from_mem;
      logic   reg_wr;
      logic   mem_wr;
      logic   is_branch;
      aluop_e alu_mode;
   } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_core_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl,
   output alu_fn_e    alu_fn
);

   // main decoder: one setting of every mux select and strobe per class
   always_comb begin
      ctrl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
               reg_wr: 1'b0, mem_wr: 1'b0, is_branch: 1'b0,
               alu_mode: AOP_ADD};
      case (opcode)
         OPC_RTYPE: begin
            ctrl.dst_is_rd = 1'b1;
            ctrl.reg_wr    = 1'b1;
            ctrl.alu_mode  = AOP_FUNCT;
         end
         OPC_LW: begin
            ctrl.b_is_imm    = 1'b1;
            ctrl.wb_from_mem = 1'b1;
            ctrl.reg_wr      = 1'b1;
         end
         OPC_SW: begin
            ctrl.b_is_imm = 1'b1;
            ctrl.mem_wr   = 1'b1;
         end
         OPC_BEQ: begin
            ctrl.is_branch = 1'b1;
            ctrl.alu_mode  = AOP_SUB;
         end
         default: ;
      endcase
   end

   // ALU operation decoder
   always_comb begin
      alu_fn = ALU_ADD;
      case (ctrl.alu_mode)
         AOP_ADD: alu_fn = ALU_ADD;
         AOP_SUB: alu_fn = ALU_SUB;
         AOP_FUNCT: begin
            case (funct)
               FN_ADD:  alu_fn = ALU_ADD;
               FN_SUB:  alu_fn = ALU_SUB;
               FN_AND:  alu_fn = ALU_AND;
               FN_OR:   alu_fn = ALU_OR;
               FN_SLT:  alu_fn = ALU_SLT;
               default: alu_fn = ALU_ADD;
            endcase
         end
         default: alu_fn = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_core_pkg::*;
#(
   parameter int unsigned W           = 32,
   parameter bit          SLT_VIA_SUB = 1'b1
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_fn_e      fn,
   output logic [W-1:0] y,
   output logic         zero
);

   if (W < 8) begin : g_chk_w
      $error("sc_alu: W must be at least 8");
   end

   logic [W-1:0] diff;
   logic         lt;

   assign diff = a - b;

   if (SLT_VIA_SUB) begin : g_slt_sub
      // sign of the difference, corrected for two's-complement overflow
      logic ovf;
      assign ovf = (a[W-1] ^ b[W-1]) & (a[W-1] ^ diff[W-1]);
      assign lt  = diff[W-1] ^ ovf;
   end else begin : g_slt_cmp
      assign lt = $signed(a) < $signed(b);
   end

   always_comb begin
      case (fn)
         ALU_ADD: y = a + b;
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int unsigned W  = 32,
   parameter int unsigned AW = 5
)(
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);

   localparam int unsigned N = 1 << AW;

   if (AW < 1 || AW > 6) begin : g_chk_aw
      $error("sc_regfile: AW out of range");
   end

   // entry 0 has no storage: it reads as zero and drops writes
   logic [W-1:0] q_r [1:N-1];

   for (genvar i = 1; i < N; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (rst)
            q_r[i] <= '0;
         else if (we && wa == AW'(i))
            q_r[i] <= wd;
      end
   end

   always_comb begin
      rd1 = '0;
      rd2 = '0;
      for (int i = 1; i < N; i++) begin
         if (ra1 == AW'(i)) rd1 = q_r[i];
         if (ra2 == AW'(i)) rd2 = q_r[i];
      end
   end

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
   parameter int unsigned          W    = 32,
   parameter int unsigned          AW   = 8,
   parameter logic [(W<<AW)-1:0]   INIT = '0
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] widx,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  rd
);

   localparam int unsigned DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_chk_aw
      $error("sc_dmem: AW out of range");
   end

   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++)
            mem_q[i] <= INIT[i*W +: W];
      end else if (we) begin
         mem_q[widx] <= wd;
      end
   end

   assign rd = mem_q[widx];

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_core_pkg::*;
#(
   parameter int unsigned                   IMEM_AW     = 8,
   parameter int unsigned                   DMEM_AW     = 8,
   parameter bit                            SLT_VIA_SUB = 1'b1,
   parameter logic [(XLEN<<IMEM_AW)-1:0]    PROGRAM     = '0,
   parameter logic [(XLEN<<DMEM_AW)-1:0]    DMEM_INIT   = '0
)(
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] pc_o,
   output logic [XLEN-1:0] instr_o,
   output logic            rf_we_o,
   output logic [4:0]      rf_waddr_o,
   output logic [XLEN-1:0] rf_wdata_o,
   output logic            dm_we_o,
   output logic [XLEN-1:0] dm_addr_o,
   output logic [XLEN-1:0] dm_wdata_o
);

   if (IMEM_AW < 1 || IMEM_AW > 14) begin : g_chk_imem
      $error("sc_core: IMEM_AW out of range");
   end
   if (DMEM_AW < 1 || DMEM_AW > 10) begin : g_chk_dmem
      $error("sc_core: DMEM_AW out of range");
   end

   // ---------------- fetch ----------------
   logic [XLEN-1:0]    pc_q;
   logic [XLEN-1:0]    pc_seq;
   logic [XLEN-1:0]    pc_tgt;
   logic [XLEN-1:0]    pc_nxt;
   logic [IMEM_AW-1:0] iidx;
   int unsigned        ibit;
   logic [XLEN-1:0]    instr;

   assign pc_seq = pc_q + XLEN'(4);
   assign iidx   = pc_q[IMEM_AW+1:2];
   assign ibit   = 32'(iidx) * XLEN;
   assign instr  = PROGRAM[ibit +: XLEN];

   // ---------------- decode ----------------
   logic [5:0]        opc;
   logic [5:0]        fnc;
   logic [REG_AW-1:0] rs;
   logic [REG_AW-1:0] rt;
   logic [REG_AW-1:0] rd;
   logic [XLEN-1:0]   imm_sx;
   ctrl_t             ctl;
   alu_fn_e           afn;

   assign opc    = instr[31:26];
   assign rs     = instr[25:21];
   assign rt     = instr[20:16];
   assign rd     = instr[15:11];
   assign fnc    = instr[5:0];
   assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

   sc_ctrl u_ctrl (
      .opcode (opc),
      .funct  (fnc),
      .ctrl   (ctl),
      .alu_fn (afn)
   );

   // ---------------- register file ----------------
   logic [REG_AW-1:0] wa;
   logic [XLEN-1:0]   rv1;
   logic [XLEN-1:0]   rv2;
   logic [XLEN-1:0]   wb;

   assign wa = ctl.dst_is_rd ? rd : rt;

   sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
      .clk (clk),
      .rst (rst),
      .ra1 (rs),
      .ra2 (rt),
      .rd1 (rv1),
      .rd2 (rv2),
      .we  (ctl.reg_wr),
      .wa  (wa),
      .wd  (wb)
   );

   // ---------------- execute ----------------
   logic [XLEN-1:0] opb;
   logic [XLEN-1:0] alu_y;
   logic            alu_z;

   assign opb = ctl.b_is_imm ? imm_sx : rv2;

   sc_alu #(.W(XLEN), .SLT_VIA_SUB(SLT_VIA_SUB)) u_alu (
      .a    (rv1),
      .b    (opb),
      .fn   (afn),
      .y    (alu_y),
      .zero (alu_z)
   );

   // ---------------- memory ----------------
   logic [XLEN-1:0] mrd;

   sc_dmem #(.W(XLEN), .AW(DMEM_AW), .INIT(DMEM_INIT)) u_dmem (
      .clk  (clk),
      .rst  (rst),
      .we   (ctl.mem_wr),
      .widx (alu_y[DMEM_AW+1:2]),
      .wd   (rv2),
      .rd   (mrd)
   );

   assign wb = ctl.wb_from_mem ? mrd : alu_y;

   // ---------------- next PC ----------------
   assign pc_tgt = pc_seq + {imm_sx[XLEN-3:0], 2'b00};
   assign pc_nxt = (ctl.is_branch && alu_z) ? pc_tgt : pc_seq;

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_nxt;
   end

   // ---------------- observation ----------------
   assign pc_o       = pc_q;
   assign instr_o    = instr;
   assign rf_we_o    = ctl.reg_wr;
   assign rf_waddr_o = wa;
   assign rf_wdata_o = wb;
   assign dm_we_o    = ctl.mem_wr;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = rv2;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc_o,
   input logic [31:0] instr_o,
   input logic        rf_we_o,
   input logic [4:0]  rf_waddr_o,
   input logic        dm_we_o
);

   assert_pc_reset_R1: assert property (@(posedge clk)
      rst |=> pc_o == 32'd0);

   assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
      (instr_o[31:26] != 6'h04) |=> pc_o == $past(pc_o) + 32'd4);

   assert_branch_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      (instr_o[31:26] == 6'h04) |-> (!rf_we_o && !dm_we_o));

   assert_rtype_dst_R4: assert property (@(posedge clk) disable iff (rst)
      (instr_o[31:26] == 6'h00) |->
         (rf_we_o && rf_waddr_o == instr_o[15:11] && !dm_we_o));

   assert_load_no_store_R5: assert property (@(posedge clk) disable iff (rst)
      (instr_o[31:26] == 6'h23) |->
         (rf_we_o && rf_waddr_o == instr_o[20:16] && !dm_we_o));

   assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
      (instr_o[31:26] == 6'h2B) |-> (dm_we_o && !rf_we_o));

endmodule

bind sc_core sc_core_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .pc_o       (pc_o),
   .instr_o    (instr_o),
   .rf_we_o    (rf_we_o),
   .rf_waddr_o (rf_waddr_o),
   .dm_we_o    (dm_we_o)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

   function automatic logic [31:0] enc_r(input logic [4:0] s, input logic [4:0] t,
                                         input logic [4:0] d, input logic [5:0] f);
      return {6'h00, s, t, d, 5'd0, f};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s,
                                         input logic [4:0] t, input logic [15:0] imm);
      return {op, s, t, imm};
   endfunction

   function automatic logic [31:0] instr_at(input int idx);
      case (idx)
         0:  return enc_i(6'h23, 5'd0, 5'd1, 16'd0);      // lw r1,0(r0)
         1:  return enc_i(6'h23, 5'd0, 5'd2, 16'd4);      // lw r2,4(r0)
         2:  return enc_i(6'h23, 5'd0, 5'd3, 16'd8);      // lw r3,8(r0)
         3:  return enc_r(5'd1, 5'd2, 5'd4, 6'h20);       // add r4
         4:  return enc_r(5'd1, 5'd2, 5'd5, 6'h22);       // sub r5
         5:  return enc_r(5'd2, 5'd1, 5'd6, 6'h22);       // sub r6 (negative)
         6:  return enc_r(5'd1, 5'd2, 5'd7, 6'h24);       // and r7
         7:  return enc_r(5'd1, 5'd3, 5'd8, 6'h25);       // or r8
         8:  return enc_r(5'd3, 5'd1, 5'd9, 6'h2A);       // slt r9 = (-16<7)
         9:  return enc_r(5'd1, 5'd3, 5'd10, 6'h2A);      // slt r10 = (7<-16)
         10: return enc_r(5'd1, 5'd1, 5'd0, 6'h20);       // add r0 (dropped)
         11: return enc_r(5'd0, 5'd0, 5'd11, 6'h20);      // add r11,r0,r0
         12: return enc_i(6'h2B, 5'd0, 5'd4, 16'd16);     // sw r4,16(r0)
         13: return enc_i(6'h23, 5'd0, 5'd12, 16'd16);    // lw r12,16(r0)
         14: return enc_i(6'h04, 5'd1, 5'd2, 16'd2);      // beq not taken
         15: return enc_i(6'h2B, 5'd0, 5'd5, 16'd20);     // sw r5,20(r0)
         16: return enc_i(6'h04, 5'd4, 5'd12, 16'd2);     // beq taken -> 19
         17: return enc_i(6'h2B, 5'd0, 5'd1, 16'd24);     // skipped
         18: return enc_i(6'h2B, 5'd0, 5'd2, 16'd28);     // skipped
         19: return enc_i(6'h2B, 5'd4, 5'd9, 16'hFFFC);   // sw r9,-4(r4)
         20: return enc_i(6'h23, 5'd4, 5'd13, 16'hFFFC);  // lw r13,-4(r4)
         21: return enc_i(6'h04, 5'd0, 5'd0, 16'd1);      // beq -> 23
         22: return enc_i(6'h2B, 5'd0, 5'd2, 16'd40);     // skipped
         23: return enc_r(5'd0, 5'd13, 5'd14, 6'h22);     // sub r14
         24: return enc_r(5'd15, 5'd13, 5'd15, 6'h20);    // loop: r15 += r13
         25: return enc_i(6'h04, 5'd15, 5'd1, 16'd1);     // exit when r15==r1
         26: return enc_i(6'h04, 5'd0, 5'd0, 16'hFFFD);   // back to 24
         27: return enc_i(6'h2B, 5'd0, 5'd15, 16'd32);    // sw r15,32(r0)
         28: return enc_i(6'h2B, 5'd0, 5'd14, 16'd36);    // sw r14,36(r0)
         default: return enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF); // halt loop
      endcase
   endfunction

   function automatic logic [31:0] dinit_at(input int idx);
      case (idx)
         0:  return 32'd7;
         1:  return 32'd5;
         2:  return 32'hFFFF_FFF0;
         3:  return 32'h0F0F_00FF;
         default: return 32'hA500_0000 ^ 32'(idx);
      endcase
   endfunction

   function automatic logic [256*32-1:0] build_prog();
      logic [256*32-1:0] v;
      for (int i = 0; i < 256; i++) v[i*32 +: 32] = instr_at(i);
      return v;
   endfunction

   function automatic logic [256*32-1:0] build_dinit();
      logic [256*32-1:0] v;
      for (int i = 0; i < 256; i++) v[i*32 +: 32] = dinit_at(i);
      return v;
   endfunction

   localparam logic [256*32-1:0] PROG  = build_prog();
   localparam logic [256*32-1:0] DINIT = build_dinit();
   localparam logic [31:0]       HALT_PC = 32'd116;

   logic        clk;
   logic        rst;
   logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic        rf_we_o, dm_we_o;
   logic [4:0]  rf_waddr_o;

   sc_core #(.IMEM_AW(8), .DMEM_AW(8), .PROGRAM(PROG), .DMEM_INIT(DINIT)) u_dut (
      .clk        (clk),
      .rst        (rst),
      .pc_o       (pc_o),
      .instr_o    (instr_o),
      .rf_we_o    (rf_we_o),
      .rf_waddr_o (rf_waddr_o),
      .rf_wdata_o (rf_wdata_o),
      .dm_we_o    (dm_we_o),
      .dm_addr_o  (dm_addr_o),
      .dm_wdata_o (dm_wdata_o)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   // behavioural reference machine
   logic [31:0] m_reg [32];
   logic [31:0] m_mem [256];
   logic [31:0] m_pc;
   string       pc_tag = "R2";
   bit          after_rst = 1'b0;

   task automatic model_step();
      logic [31:0] ins, a, b, sx, res, addr;
      logic [5:0]  op, fn;
      logic [4:0]  s, t, d;
      if (rst) begin
         m_pc = 32'd0;
         for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
         for (int i = 0; i < 256; i++) m_mem[i] = dinit_at(i);
         after_rst = 1'b1;
         pc_tag = "R2";
         return;
      end
      if (after_rst) begin
         chk("R1", "pc after reset", pc_o, 32'd0);
         after_rst = 1'b0;
      end
      chk(pc_tag, "pc", pc_o, m_pc);
      ins = instr_at(int'(m_pc[31:2]));
      chk("R2", "fetched word", instr_o, ins);
      op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11]; fn = ins[5:0];
      a  = m_reg[s]; b = m_reg[t];
      sx = {{16{ins[15]}}, ins[15:0]};
      addr = a + sx;
      pc_tag = "R2";
      case (op)
         6'h00: begin
            case (fn)
               6'h20: res = a + b;
               6'h22: res = a - b;
               6'h24: res = a & b;
               6'h25: res = a | b;
               default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            endcase
            chk("R4", "rf write strobe", {31'd0, rf_we_o}, 32'd1);
            chk("R4", "rf write index", {27'd0, rf_waddr_o}, {27'd0, d});
            chk("R4", "rf write data", rf_wdata_o, res);
            chk("R4", "no store", {31'd0, dm_we_o}, 32'd0);
            if (m_pc == 32'd44)
               chk("R7", "sum of r0+r0 after write to r0", rf_wdata_o, 32'd0);
            if (d != 5'd0) m_reg[d] = res;
            m_pc = m_pc + 32'd4;
         end
         6'h23: begin
            chk("R5", "rf write strobe", {31'd0, rf_we_o}, 32'd1);
            chk("R5", "rf write index", {27'd0, rf_waddr_o}, {27'd0, t});
            chk("R5", "load data", rf_wdata_o, m_mem[addr[9:2]]);
            chk("R5", "no store on load", {31'd0, dm_we_o}, 32'd0);
            if (t != 5'd0) m_reg[t] = m_mem[addr[9:2]];
            m_pc = m_pc + 32'd4;
         end
         6'h2B: begin
            chk("R6", "no rf write", {31'd0, rf_we_o}, 32'd0);
            chk("R6", "store strobe", {31'd0, dm_we_o}, 32'd1);
            chk("R6", "store address", dm_addr_o, addr);
            chk("R6", "store data", dm_wdata_o, b);
            m_mem[addr[9:2]] = b;
            m_pc = m_pc + 32'd4;
         end
         default: begin
            chk("R3", "no rf write", {31'd0, rf_we_o}, 32'd0);
            chk("R3", "no store", {31'd0, dm_we_o}, 32'd0);
            if (a == b) m_pc = m_pc + 32'd4 + {sx[29:0], 2'b00};
            else        m_pc = m_pc + 32'd4;
            pc_tag = "R3";
         end
      endcase
   endtask

   always @(negedge clk) begin
      if (!done) model_step();
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 5000);
         report();
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // run partway into the counting loop, then reset mid-program (R1)
      repeat (40) @(posedge clk);
      #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      repeat (100) @(posedge clk);
      #2;
      chk("R3", "parked at halt loop", pc_o, HALT_PC);
      chk("R3", "model parked at halt loop", m_pc, HALT_PC);
      done = 1'b1;
      report();
      $finish;
   end

endmodule